// File: doc/BRIEF.md
# Dual-Space Internal Data Memory Decoder

This block is the internal data memory front end of an 8-bit CPU core. It holds 256 bytes of RAM and connects to a bus of special function registers (SFRs) that live in the peripherals. The CPU reaches it through one read/write port: an address, write data, write and read strobes, and a flag that says whether the access uses indirect addressing. It also runs a hardware stack with an 8-bit stack pointer, driven by push and pop requests.

The lower half of the address range (0x00 to 0x7F) is plain RAM for every access. The upper half (0x80 to 0xFF) is shared by two separate stores. A direct access goes out on the SFR bus. An indirect access, and every stack access, uses the upper 128 bytes of RAM. The address never decides between the two: the addressing mode does.

A parameter mask lists which SFR addresses have a register behind them. A direct read of an address that has no register returns zero. A direct write to such an address is dropped and never reaches the bus. Read data is registered: RAM data and SFR bus data both appear on the cycle after the request.

Top module: `dual_space_dmem`

## Requirements
- R1: For addresses 0x00 to 0x7F, reads and writes use RAM whatever the value of `cpu_indirect`.
- R2: A direct access (`cpu_indirect`=0) to 0x80 to 0xFF goes on the SFR bus in the same cycle. `sfr_addr` carries the address, `sfr_we`/`sfr_re` follow the strobes, and RAM is not written.
- R3: An indirect access to 0x80 to 0xFF uses the upper RAM. `sfr_we` and `sfr_re` stay low, so an SFR at the same address is untouched.
- R4: Only the SFRs at 0x80, 0x88, 0x90, 0x98, 0xA0, 0xA8, 0xB0, 0xB8, 0xC8 to 0xCD, 0xD0, 0xE0 and 0xF0 exist. A direct read of any other upper address returns 0x00. A direct write to one raises no `sfr_we`.
- R5: A push adds one to the stack pointer, wrapping from 0xFF to 0x00, and writes `cpu_wdata` to RAM at the new pointer. This is always a RAM access, including upper addresses.
- R6: A pop reads RAM at the current pointer, returns that byte as read data, and then subtracts one from the pointer.
- R7: After reset, `sp_out` is 0x07, `cpu_rdata` is 0x00 and `rdata_vld` is 0.
- R8: When both are raised, push wins over pop. During any stack request, the CPU port strobes are ignored and the SFR bus stays idle.
- R9: `rdata_vld` is high exactly on the cycle after an accepted read or pop. `cpu_rdata` changes only then and holds its value otherwise.
- R10: A write followed by a read of the same location in the next cycle returns the new value.
- R11: A cycle with both `cpu_we` and `cpu_re` returns the contents the location had before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | CPU access address |
| cpu_wdata | input | 8 | Write data; also the data for a push |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| stk_push | input | 1 | Stack push request |
| stk_pop | input | 1 | Stack pop request |
| cpu_rdata | output | 8 | Registered read data |
| rdata_vld | output | 1 | Read data returned this cycle |
| sp_out | output | 8 | Current stack pointer |
| sfr_addr | output | 8 | SFR bus address |
| sfr_wdata | output | 8 | SFR bus write data |
| sfr_we | output | 1 | SFR bus write strobe |
| sfr_re | output | 1 | SFR bus read strobe |
| sfr_rdata | input | 8 | SFR bus read data (combinational) |

## Verification
The bench uses the same upper address in both modes: it writes 0xA0 indirectly and then reads it directly. A decoder that switched on the address alone would corrupt the SFR or return the RAM byte. The SFR stub drives nonzero data at addresses that have no register, so a missing zero gate shows up as a wrong value, and a write leak shows up as a stray `sfr_we`. The bench pushes the stack past 0x80 and then around 0xFF, which exposes a stack routed by address or a pointer that saturates instead of wrapping. Read-after-write, read-with-write and push/pop collisions catch a wrong read order or a wrong priority.

// File: rtl/idm_pkg.sv
package idm_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_CPU  = 2'd1,
      OP_PUSH = 2'd2,
      OP_POP  = 2'd3
   } idm_op_e;

   typedef enum logic {
      SRC_RAM = 1'b0,
      SRC_SFR = 1'b1
   } idm_src_e;

   typedef struct packed {
      idm_op_e op;
      logic    ram_we;
      logic    ram_re;
      logic    sfr_we;
      logic    sfr_re;
      logic    sfr_rd;
      logic    sfr_hit;
      logic    rd_fire;
   } idm_ctl_t;

endpackage

// File: rtl/idm_route.sv
module idm_route
   import idm_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter logic [(2**(AW-1))-1:0] SFR_MAP = '1
) (
   input  logic [AW-1:0] addr,
   input  logic          we,
   input  logic          re,
   input  logic          indirect,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] sp,
   output logic [AW-1:0] ram_addr,
   output idm_ctl_t      ctl
);

   localparam int unsigned OFS_W = AW - 1;

   logic [OFS_W-1:0] ofs;
   logic             upper;
   logic             to_sfr;
   logic             hit;
   idm_op_e          op;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("idm_route: AW must be at least 2");
      end
   endgenerate

   assign ofs    = addr[OFS_W-1:0];
   assign upper  = addr[AW-1];
   assign to_sfr = upper & ~indirect;
   assign hit    = SFR_MAP[ofs];

   always_comb begin
      if (push)                 op = OP_PUSH;
      else if (pop)             op = OP_POP;
      else if (we | re)         op = OP_CPU;
      else                      op = OP_IDLE;
   end

   always_comb begin
      ctl         = '0;
      ctl.op      = op;
      ram_addr    = addr;
      unique case (op)
         OP_PUSH: begin
            ram_addr   = sp + 1'b1;
            ctl.ram_we = 1'b1;
         end
         OP_POP: begin
            ram_addr    = sp;
            ctl.ram_re  = 1'b1;
            ctl.rd_fire = 1'b1;
         end
         OP_CPU: begin
            ctl.ram_we  = we & ~to_sfr;
            ctl.ram_re  = re & ~to_sfr;
            ctl.sfr_we  = we & to_sfr & hit;
            ctl.sfr_re  = re & to_sfr & hit;
            ctl.sfr_rd  = re & to_sfr;
            ctl.sfr_hit = hit;
            ctl.rd_fire = re;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/idm_stack.sv
module idm_stack
   import idm_pkg::*;
#(
   parameter int unsigned AW      = 8,
   parameter logic [AW-1:0] SP_INIT = 8'h07
) (
   input  logic          clk,
   input  logic          rst_n,
   input  idm_op_e       op,
   output logic [AW-1:0] sp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= SP_INIT;
      end else begin
         unique case (op)
            OP_PUSH: sp <= sp + 1'b1;
            OP_POP:  sp <= sp - 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);

   localparam int unsigned DEPTH = 2 ** AW;

   logic [DW-1:0] mem [DEPTH];

   generate
      if (DEPTH > 4096) begin : g_too_deep
         $error("idm_ram: depth above 4096 entries");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   // read-first: the same edge sees the old word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (re) q <= mem[addr];
   end

endmodule

// File: rtl/dual_space_dmem.sv
module dual_space_dmem
   import idm_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8,
   parameter logic [AW-1:0] SP_INIT = 8'h07,
   parameter logic [(2**(AW-1))-1:0] SFR_MAP =
      128'h0001_0001_0001_3F00_0101_0101_0101_0101
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   input  logic          cpu_we,
   input  logic          cpu_re,
   input  logic          cpu_indirect,
   input  logic          stk_push,
   input  logic          stk_pop,
   output logic [DW-1:0] cpu_rdata,
   output logic          rdata_vld,
   output logic [AW-1:0] sp_out,
   output logic [AW-1:0] sfr_addr,
   output logic [DW-1:0] sfr_wdata,
   output logic          sfr_we,
   output logic          sfr_re,
   input  logic [DW-1:0] sfr_rdata
);

   localparam int unsigned OFS_W = AW - 1;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("dual_space_dmem: DW must be positive");
      end
   endgenerate

   idm_ctl_t      ctl;
   logic [AW-1:0] ram_addr;
   logic [AW-1:0] sp;
   logic [DW-1:0] ram_q;
   logic [DW-1:0] sfr_q;
   idm_src_e      src_q;
   logic          vld_q;

   idm_route #(.AW(AW), .SFR_MAP(SFR_MAP)) u_route (
      .addr     (cpu_addr),
      .we       (cpu_we),
      .re       (cpu_re),
      .indirect (cpu_indirect),
      .push     (stk_push),
      .pop      (stk_pop),
      .sp       (sp),
      .ram_addr (ram_addr),
      .ctl      (ctl)
   );

   idm_stack #(.AW(AW), .SP_INIT(SP_INIT)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (ctl.op),
      .sp    (sp)
   );

   idm_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl.ram_we),
      .re    (ctl.ram_re),
      .addr  (ram_addr),
      .wdata (cpu_wdata),
      .q     (ram_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         src_q <= SRC_RAM;
         sfr_q <= '0;
      end else begin
         vld_q <= ctl.rd_fire;
         if (ctl.sfr_rd) begin
            src_q <= SRC_SFR;
            sfr_q <= ctl.sfr_hit ? sfr_rdata : '0;
         end else if (ctl.ram_re) begin
            src_q <= SRC_RAM;
         end
      end
   end

   assign cpu_rdata = (src_q == SRC_SFR) ? sfr_q : ram_q;
   assign rdata_vld = vld_q;
   assign sp_out    = sp;
   assign sfr_addr  = cpu_addr;
   assign sfr_wdata = cpu_wdata;
   assign sfr_we    = ctl.sfr_we;
   assign sfr_re    = ctl.sfr_re;

   logic cpu_slot;
   assign cpu_slot = ~stk_push & ~stk_pop;

   // R2
   direct_upper_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_slot && cpu_addr[AW-1] && !cpu_indirect) |-> (!ctl.ram_we && !ctl.ram_re));

   // R3
   indirect_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_indirect |-> (!sfr_we && !sfr_re));

   // R4
   unimpl_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_slot && cpu_re && !cpu_indirect && cpu_addr[AW-1] &&
       !SFR_MAP[cpu_addr[OFS_W-1:0]]) |=> (cpu_rdata == '0));

   // R5
   push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push |=> (sp_out == AW'($past(sp_out) + 1'b1)));

   // R6
   pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_pop && !stk_push) |=> (sp_out == AW'($past(sp_out) - 1'b1)));

   // R8
   stack_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_push || stk_pop) |-> (!sfr_we && !sfr_re));

   // R9
   rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stk_push && (stk_pop || cpu_re)) |=> rdata_vld);

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_push || (!stk_pop && !cpu_re)) |=> (!rdata_vld && $stable(cpu_rdata)));

endmodule

// File: tb/dual_space_dmem_tb.sv
module dual_space_dmem_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cpu_addr = '0, cpu_wdata = '0;
   logic       cpu_we = 0, cpu_re = 0, cpu_indirect = 0, stk_push = 0, stk_pop = 0;
   logic [7:0] cpu_rdata, sp_out, sfr_addr, sfr_wdata, sfr_rdata;
   logic       rdata_vld, sfr_we, sfr_re;

   always #10 clk = ~clk;

   dual_space_dmem u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_indirect(cpu_indirect),
      .stk_push(stk_push), .stk_pop(stk_pop), .cpu_rdata(cpu_rdata),
      .rdata_vld(rdata_vld), .sp_out(sp_out), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_we(sfr_we), .sfr_re(sfr_re),
      .sfr_rdata(sfr_rdata)
   );

   // peripheral stub: a register at every upper address, nonzero at start
   logic [7:0] sregs [128];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) sregs[i] <= 8'h5A ^ 8'(i);
      end else if (sfr_we) begin
         sregs[sfr_addr[6:0]] <= sfr_wdata;
      end
   end
   assign sfr_rdata = sregs[sfr_addr[6:0]];

   int nvec = 0, nbad = 0;
   int mem [256];
   int m_sp = 7;
   int m_rd = 0;
   bit done = 0;

   function automatic bit impl_f(input int a);
      case (a)
         'h80, 'h88, 'h90, 'h98, 'hA0, 'hA8, 'hB0, 'hB8,
         'hC8, 'hC9, 'hCA, 'hCB, 'hCC, 'hCD, 'hD0, 'hE0, 'hF0: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // one clock of stimulus against the behavioural reference
   task automatic cyc(input int a, input int wd, input bit we, input bit re,
                      input bit ind, input bit push, input bit pop);
      bit cpu, to_sfr, hit, e_we, e_re, e_vld;
      string tag;
      cpu_addr = 8'(a); cpu_wdata = 8'(wd); cpu_we = we; cpu_re = re;
      cpu_indirect = ind; stk_push = push; stk_pop = pop;
      cpu    = !push && !pop;
      to_sfr = cpu && a >= 'h80 && !ind;
      hit    = impl_f(a);
      e_we   = to_sfr && we && hit;
      e_re   = to_sfr && re && hit;
      tag = !cpu ? "R8" : (to_sfr ? (hit ? "R2" : "R4") : (a >= 'h80 ? "R3" : "R1"));
      #1;
      chk(tag, sfr_we, e_we);
      chk(tag, sfr_re, e_re);
      if (e_we || e_re) chk("R2 addr", sfr_addr, a);
      e_vld = 0;
      if (push) begin
         m_sp = (m_sp + 1) & 255;
         mem[m_sp] = wd & 255;
      end else if (pop) begin
         m_rd = mem[m_sp];
         e_vld = 1;
         m_sp = (m_sp - 1) & 255;
      end else begin
         if (re) begin
            e_vld = 1;
            if (to_sfr) m_rd = hit ? int'(sregs[a & 127]) : 0;
            else        m_rd = mem[a];
         end
         if (we && !to_sfr) mem[a] = wd & 255;   // R11: after the read
      end
      @(posedge clk); @(negedge clk);
      chk("R9 vld", rdata_vld, e_vld);
      if (m_rd >= 0) chk(push ? "R5/R9" : (pop ? "R6" : "R9 data"), cpu_rdata, m_rd);
      chk(push ? "R5 sp" : (pop ? "R6 sp" : "R8 sp"), sp_out, m_sp);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = -1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7
      chk("R7 sp", sp_out, 8'h07);
      chk("R7 rdata", cpu_rdata, 0);
      chk("R7 vld", rdata_vld, 0);

      // R1: lower half, both modes
      cyc('h10, 'h11, 1, 0, 0, 0, 0);
      cyc('h10, 0, 0, 1, 1, 0, 0);
      cyc('h7F, 'hC3, 1, 0, 1, 0, 0);
      cyc('h7F, 0, 0, 1, 0, 0, 0);
      // R10: back-to-back write then read
      cyc('h20, 'hA5, 1, 0, 0, 0, 0);
      cyc('h20, 0, 0, 1, 0, 0, 0);
      // R2: implemented SFR write and read back
      cyc('hA0, 'h3C, 1, 0, 0, 0, 0);
      cyc('hA0, 0, 0, 1, 0, 0, 0);
      // R3: indirect at same address leaves SFR alone
      cyc('hA0, 'h77, 1, 0, 1, 0, 0);
      cyc('hA0, 0, 0, 1, 0, 0, 0);
      cyc('hA0, 0, 0, 1, 1, 0, 0);
      // R4: unimplemented SFR
      cyc('h81, 'hEE, 1, 0, 0, 0, 0);
      cyc('h81, 0, 0, 1, 0, 0, 0);
      cyc('hFF, 0, 0, 1, 0, 0, 0);
      // R11: write with read returns prior contents
      cyc('h20, 'h0F, 1, 1, 0, 0, 0);
      cyc('h20, 0, 0, 1, 0, 0, 0);
      cyc('hB0, 'h99, 1, 1, 0, 0, 0);
      cyc('hB0, 0, 0, 1, 0, 0, 0);
      // R9: idle cycles hold data
      cyc(0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0);
      // R5: push into upper RAM, then across the wrap
      for (int i = 0; i < 130; i++) cyc('hA0, i + 1, 0, 0, 0, 1, 0);
      cyc('h85, 0, 0, 1, 1, 0, 0);
      cyc('h88, 0, 0, 1, 0, 0, 0);
      // R6: pops
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 125; i++) cyc(0, 'hF0 ^ i, 0, 0, 0, 1, 0);
      cyc(0, 0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 0, 1);
      // R8: push beats pop, and CPU strobes ignored during stack ops
      cyc('hA0, 'h5E, 1, 1, 0, 1, 1);
      cyc('hA0, 'h12, 1, 1, 0, 0, 1);
      cyc('hA0, 0, 0, 1, 0, 0, 0);
      // mixed traffic
      for (int n = 0; n < 3000; n++) begin
         int r = int'($urandom % 12);
         int a = int'($urandom % 256);
         if (r == 0)      cyc(a, int'($urandom % 256), 0, 0, 0, 1, 0);
         else if (r == 1) cyc(a, 0, 0, 0, 0, 0, 1);
         else if (r == 2) cyc(a, int'($urandom % 256), 1, 1, $urandom % 2, 1, 1);
         else             cyc(a, int'($urandom % 256), $urandom % 2, $urandom % 2,
                              $urandom % 2, 0, 0);
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule